// File: doc/BRIEF.md
# Two-Cluster Duplicated Register File

This block is an integer register file kept as two full copies, one per execution cluster. Each cluster has its own single write port and its own group of read ports. A write is placed in the writer's own copy at the clock edge that ends the write cycle. It reaches the other cluster's copy one edge later. Between those two edges, the other copy marks that register as stale.

Each read port is a small state machine. A read that finds its copy up to date returns data one cycle after the request. A read that finds the register stale first raises a delay flag for one cycle. It then returns the correct value one cycle after that. Every response also reports which cluster last wrote the register, so that steering logic can keep dependent work in the producing cluster.

The read port states are RP_IDLE (no response this cycle), RP_DONE (data valid this cycle) and RP_STALL (delay flag raised; the held address is read again). The transitions are:
- idle_to_done / done_to_done: a request to a fresh register.
- idle_to_stall / done_to_stall: a request to a stale register.
- stall_to_done: always, on the retry.
- idle_to_idle / done_to_idle: no request.

Top module: `dual_cluster_regfile`

## Requirements
- R1: After reset every register reads as 0 with owner 0 in both copies, and no port shows valid or delayed before a request.
- R2: A register written by cluster c can be read by a port of cluster c in the next cycle. The new data and rd_valid=1 appear one cycle after the request, with rd_delayed=0.
- R3: A read by the other cluster in the cycle right after the write shows rd_delayed=1 and rd_valid=0 one cycle after the request. The next cycle shows rd_valid=1 with the new data.
- R4: A read by the other cluster issued two or more cycles after the write has normal latency and returns the new data.
- R5: A read issued in the same cycle as a write to the same register returns the previous value, in both clusters.
- R6: When both clusters write the same register in one cycle, cluster 0's data ends up in both copies, cluster 1's write is discarded, and the owner becomes 0.
- R7: rd_owner reports the writer of the register returned: 0 for cluster 0, 1 for cluster 1.
- R8: A request presented to a port during its stall cycle is ignored. The port returns the held register, then goes idle.
- R9: The four read ports of each cluster work at once on different registers. The port index p of cluster c is flat index c*4+p in every per-port vector.
- R10: A local write wins over a propagation from the other cluster that lands on the same register at the same edge. The local copy then holds the newest data and is not stale.
- R11: A cycle with no request produces rd_valid=0 and rd_delayed=0 on that port one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 2 | Write enable, bit c for cluster c |
| wr_addr | input | 14 | Write register index, slice [c*7 +: 7] |
| wr_data | input | 64 | Write data, slice [c*32 +: 32] |
| rd_req | input | 8 | Read request per port (flat index c*4+p) |
| rd_addr | input | 56 | Read register index per port, slice [i*7 +: 7] |
| rd_valid | output | 8 | Response data valid per port |
| rd_delayed | output | 8 | Response postponed one cycle by a stale copy |
| rd_data | output | 256 | Response data per port, slice [i*32 +: 32] |
| rd_owner | output | 8 | Cluster that last wrote the returned register |

## Verification
A write lands locally at the edge that ends its cycle and remotely one edge later. A fresh read's response is due one cycle after the request. A stale read's delay flag is due one cycle after the request, and its data one cycle after that. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next one, so each check lands in the exact cycle its response is due. The stale window is hit on purpose by issuing the remote read in the cycle directly after a write, and it is avoided on purpose by inserting idle cycles.

// File: rtl/rfdc_pkg.sv
package rfdc_pkg;
    typedef enum logic [1:0] {
        RP_IDLE  = 2'd0,
        RP_DONE  = 2'd1,
        RP_STALL = 2'd2
    } rport_state_e;
endpackage

// File: rtl/rfdc_copy.sv
module rfdc_copy #(
    parameter int NUM_REGS = 80,
    parameter int DATA_W   = 32,
    parameter int RPORTS   = 4,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lw_en_i,
    input  logic [AW-1:0]     lw_addr_i,
    input  logic [DATA_W-1:0] lw_data_i,
    input  logic              pr_en_i,
    input  logic [AW-1:0]     pr_addr_i,
    input  logic [DATA_W-1:0] pr_data_i,
    input  logic              mark_en_i,
    input  logic [AW-1:0]     mark_addr_i,
    input  logic [AW-1:0]     rd_addr_i [RPORTS],
    output logic [DATA_W-1:0] rd_word_o [RPORTS],
    output logic              rd_stale_o [RPORTS]
);
    logic [DATA_W-1:0]   mem_q [NUM_REGS];
    logic [NUM_REGS-1:0] stale_q;
    logic [NUM_REGS-1:0] stale_d;

    // Data storage: propagation first, local write last so it wins (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else begin
            if (pr_en_i) mem_q[pr_addr_i] <= pr_data_i;
            if (lw_en_i) mem_q[lw_addr_i] <= lw_data_i;
        end
    end

    always_comb begin
        stale_d = stale_q;
        if (pr_en_i)   stale_d[pr_addr_i]   = 1'b0;
        if (lw_en_i)   stale_d[lw_addr_i]   = 1'b0;
        if (mark_en_i) stale_d[mark_addr_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stale_q <= '0;
        else        stale_q <= stale_d;
    end

    for (genvar p = 0; p < RPORTS; p++) begin : g_rd
        assign rd_word_o[p]  = mem_q[rd_addr_i[p]];
        assign rd_stale_o[p] = stale_q[rd_addr_i[p]];
    end

    // R3
    set_marks_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_en_i && !(lw_en_i && lw_addr_i == mark_addr_i))
        |=> stale_q[$past(mark_addr_i)]);

    // R4
    prop_clears_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_en_i && !(mark_en_i && mark_addr_i == pr_addr_i))
        |=> !stale_q[$past(pr_addr_i)]);

    // R10
    local_clears_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lw_en_i && !(mark_en_i && mark_addr_i == lw_addr_i))
        |=> !stale_q[$past(lw_addr_i)]);
endmodule

// File: rtl/rfdc_read_port.sv
module rfdc_read_port #(
    parameter int NUM_REGS = 80,
    parameter int DATA_W   = 32,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [AW-1:0]     addr_i,
    output logic [AW-1:0]     sel_addr_o,
    input  logic [DATA_W-1:0] word_i,
    input  logic              stale_i,
    input  logic              owner_i,
    output logic              valid_o,
    output logic              delayed_o,
    output logic [DATA_W-1:0] data_o,
    output logic              owner_o
);
    import rfdc_pkg::*;

    rport_state_e      state_q, state_d;
    logic [AW-1:0]     held_q;
    logic [DATA_W-1:0] data_q;
    logic              owner_q;

    assign sel_addr_o = (state_q == RP_STALL) ? held_q : addr_i;

    always_comb begin
        state_d = RP_IDLE;
        unique case (state_q)
            RP_STALL: state_d = RP_DONE;
            RP_IDLE, RP_DONE: begin
                if (req_i) state_d = stale_i ? RP_STALL : RP_DONE;
                else       state_d = RP_IDLE;
            end
            default: state_d = RP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q  <= '0;
            data_q  <= '0;
            owner_q <= 1'b0;
        end else begin
            if (state_d == RP_STALL) held_q <= addr_i;
            if (state_d == RP_DONE) begin
                data_q  <= word_i;
                owner_q <= owner_i;
            end
        end
    end

    always_comb begin
        valid_o   = 1'b0;
        delayed_o = 1'b0;
        unique case (state_q)
            RP_IDLE:  ;
            RP_DONE:  valid_o   = 1'b1;
            RP_STALL: delayed_o = 1'b1;
            default:  ;
        endcase
    end
    assign data_o  = data_q;
    assign owner_o = owner_q;

    // R3
    stall_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        delayed_o |=> (valid_o && !delayed_o));

    // R2
    fresh_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!delayed_o && req_i && !stale_i) |=> (valid_o && !delayed_o));

    // R11
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!delayed_o && !req_i) |=> (!valid_o && !delayed_o));
endmodule

// File: rtl/dual_cluster_regfile.sv
module dual_cluster_regfile #(
    parameter int NUM_REGS = 80,
    parameter int DATA_W   = 32,
    parameter int RPORTS   = 4,
    localparam int NCL     = 2,
    localparam int AW      = $clog2(NUM_REGS),
    localparam int NRP     = NCL * RPORTS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCL-1:0]        wr_en,
    input  logic [NCL*AW-1:0]     wr_addr,
    input  logic [NCL*DATA_W-1:0] wr_data,
    input  logic [NRP-1:0]        rd_req,
    input  logic [NRP*AW-1:0]     rd_addr,
    output logic [NRP-1:0]        rd_valid,
    output logic [NRP-1:0]        rd_delayed,
    output logic [NRP*DATA_W-1:0] rd_data,
    output logic [NRP-1:0]        rd_owner
);
    logic [AW-1:0]       w_addr [NCL];
    logic [DATA_W-1:0]   w_data [NCL];
    logic [NCL-1:0]      acc;
    logic                collide;

    logic [NCL-1:0]      pend_vld_q;
    logic [AW-1:0]       pend_addr_q [NCL];
    logic [DATA_W-1:0]   pend_data_q [NCL];
    logic [NUM_REGS-1:0] owner_q;

    logic [AW-1:0]       sel_a   [NCL][RPORTS];
    logic [DATA_W-1:0]   word_a  [NCL][RPORTS];
    logic                stale_a [NCL][RPORTS];

    for (genvar c = 0; c < NCL; c++) begin : g_split
        assign w_addr[c] = wr_addr[c*AW +: AW];
        assign w_data[c] = wr_data[c*DATA_W +: DATA_W];
    end

    // Same-register collision: cluster 0 wins, cluster 1 dropped (R6)
    assign collide = wr_en[0] && wr_en[1] && (w_addr[0] == w_addr[1]);
    assign acc[0]  = wr_en[0];
    assign acc[1]  = wr_en[1] && !collide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld_q <= '0;
            for (int c = 0; c < NCL; c++) begin
                pend_addr_q[c] <= '0;
                pend_data_q[c] <= '0;
            end
        end else begin
            pend_vld_q <= acc;
            for (int c = 0; c < NCL; c++) begin
                if (acc[c]) begin
                    pend_addr_q[c] <= w_addr[c];
                    pend_data_q[c] <= w_data[c];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= '0;
        end else begin
            if (acc[1]) owner_q[w_addr[1]] <= 1'b1;
            if (acc[0]) owner_q[w_addr[0]] <= 1'b0;
        end
    end

    for (genvar c = 0; c < NCL; c++) begin : g_cl
        rfdc_copy #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .RPORTS   (RPORTS)
        ) copy_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .lw_en_i     (acc[c]),
            .lw_addr_i   (w_addr[c]),
            .lw_data_i   (w_data[c]),
            .pr_en_i     (pend_vld_q[NCL-1-c]),
            .pr_addr_i   (pend_addr_q[NCL-1-c]),
            .pr_data_i   (pend_data_q[NCL-1-c]),
            .mark_en_i   (acc[NCL-1-c]),
            .mark_addr_i (w_addr[NCL-1-c]),
            .rd_addr_i   (sel_a[c]),
            .rd_word_o   (word_a[c]),
            .rd_stale_o  (stale_a[c])
        );

        for (genvar p = 0; p < RPORTS; p++) begin : g_pt
            localparam int IDX = c*RPORTS + p;
            rfdc_read_port #(
                .NUM_REGS (NUM_REGS),
                .DATA_W   (DATA_W)
            ) port_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .req_i      (rd_req[IDX]),
                .addr_i     (rd_addr[IDX*AW +: AW]),
                .sel_addr_o (sel_a[c][p]),
                .word_i     (word_a[c][p]),
                .stale_i    (stale_a[c][p]),
                .owner_i    (owner_q[sel_a[c][p]]),
                .valid_o    (rd_valid[IDX]),
                .delayed_o  (rd_delayed[IDX]),
                .data_o     (rd_data[IDX*DATA_W +: DATA_W]),
                .owner_o    (rd_owner[IDX])
            );
        end
    end

    // R6
    collision_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> (owner_q[$past(w_addr[0])] == 1'b0));

    // R7
    single_writer_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[1] && !wr_en[0]) |=> (owner_q[$past(w_addr[1])] == 1'b1));
endmodule

// File: tb/dual_cluster_regfile_tb.sv
module dual_cluster_regfile_tb_top;
    localparam int NR = 80;
    localparam int DW = 32;
    localparam int RP = 4;
    localparam int AW = $clog2(NR);
    localparam int NP = 2*RP;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      wr_en;
    logic [2*AW-1:0] wr_addr;
    logic [2*DW-1:0] wr_data;
    logic [NP-1:0]   rd_req;
    logic [NP*AW-1:0] rd_addr;
    logic [NP-1:0]   rd_valid;
    logic [NP-1:0]   rd_delayed;
    logic [NP*DW-1:0] rd_data;
    logic [NP-1:0]   rd_owner;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dual_cluster_regfile #(.NUM_REGS(NR), .DATA_W(DW), .RPORTS(RP)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_delayed(rd_delayed), .rd_data(rd_data),
        .rd_owner(rd_owner)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic clr_all();
        wr_en = '0; wr_addr = '0; wr_data = '0; rd_req = '0; rd_addr = '0;
    endtask

    task automatic set_wr(input int c, input int a, input logic [31:0] d);
        wr_en[c] = 1'b1;
        wr_addr[c*AW +: AW] = AW'(a);
        wr_data[c*DW +: DW] = d;
    endtask

    task automatic set_rd(input int c, input int p, input int a);
        rd_req[c*RP+p] = 1'b1;
        rd_addr[(c*RP+p)*AW +: AW] = AW'(a);
    endtask

    // Expect a valid response with given data and owner
    task automatic exp_hit(input int c, input int p, input logic [31:0] d,
                           input bit own, input string req);
        int i = c*RP + p;
        chk(rd_valid[i] && !rd_delayed[i], req, "valid/delayed",
            {30'd0, rd_valid[i], rd_delayed[i]}, 32'h2);
        chk(rd_data[i*DW +: DW] == d, req, "data", rd_data[i*DW +: DW], d);
        chk(rd_owner[i] == own, req, "owner", {31'd0, rd_owner[i]}, {31'd0, own});
    endtask

    task automatic exp_stall(input int c, input int p, input string req);
        int i = c*RP + p;
        chk(!rd_valid[i] && rd_delayed[i], req, "stall flags",
            {30'd0, rd_valid[i], rd_delayed[i]}, 32'h1);
    endtask

    task automatic exp_idle(input int c, input int p, input string req);
        int i = c*RP + p;
        chk(!rd_valid[i] && !rd_delayed[i], req, "idle flags",
            {30'd0, rd_valid[i], rd_delayed[i]}, 32'h0);
    endtask

    task automatic t_reset();
        clr_all();
        exp_idle(0, 0, "R1");
        exp_idle(1, 3, "R1");
        for (int c = 0; c < 2; c++)
            for (int p = 0; p < RP; p++) set_rd(c, p, 3 + p);
        step();
        for (int c = 0; c < 2; c++)
            for (int p = 0; p < RP; p++) exp_hit(c, p, 32'h0, 1'b0, "R1");
        clr_all(); step();
        exp_idle(0, 1, "R11");
    endtask

    task automatic t_local();
        clr_all(); set_wr(0, 5, 32'hA5A5_0005); step();
        clr_all(); set_rd(0, 0, 5); step();
        exp_hit(0, 0, 32'hA5A5_0005, 1'b0, "R2");
        clr_all(); set_wr(1, 6, 32'h1111_0006); step();
        clr_all(); set_rd(1, 2, 6); step();
        exp_hit(1, 2, 32'h1111_0006, 1'b1, "R7");
        clr_all(); step();
        exp_idle(1, 2, "R11");
    endtask

    task automatic t_remote_stale();
        clr_all(); set_wr(0, 10, 32'hBEEF_0010); step();
        clr_all(); set_rd(1, 1, 10); step();
        exp_stall(1, 1, "R3");
        clr_all(); step();
        exp_hit(1, 1, 32'hBEEF_0010, 1'b0, "R3");
        clr_all(); step();
    endtask

    task automatic t_remote_late();
        clr_all(); set_wr(1, 20, 32'hC0DE_0020); step();
        clr_all(); step();
        set_rd(0, 2, 20); step();
        exp_hit(0, 2, 32'hC0DE_0020, 1'b1, "R4");
        clr_all(); step();
    endtask

    task automatic t_same_cycle();
        clr_all(); set_wr(0, 30, 32'hD100_0030); step();
        clr_all(); step(); step();
        set_wr(1, 30, 32'hD200_0030); set_rd(0, 0, 30); set_rd(1, 0, 30); step();
        exp_hit(0, 0, 32'hD100_0030, 1'b0, "R5");
        exp_hit(1, 0, 32'hD100_0030, 1'b0, "R5");
        clr_all(); step(); step();
    endtask

    task automatic t_collision();
        clr_all(); set_wr(0, 40, 32'hE000_0040); set_wr(1, 40, 32'hE111_0040); step();
        clr_all(); step(); step();
        set_rd(0, 1, 40); set_rd(1, 3, 40); step();
        exp_hit(0, 1, 32'hE000_0040, 1'b0, "R6");
        exp_hit(1, 3, 32'hE000_0040, 1'b0, "R6");
        clr_all(); step();
    endtask

    task automatic t_stall_ignore();
        clr_all(); set_wr(1, 50, 32'hF000_0050); step();
        clr_all(); set_rd(0, 3, 50); step();
        exp_stall(0, 3, "R8");
        clr_all(); set_rd(0, 3, 51); step();
        exp_hit(0, 3, 32'hF000_0050, 1'b1, "R8");
        clr_all(); step();
        exp_idle(0, 3, "R8");
    endtask

    task automatic t_ports();
        for (int i = 0; i < 8; i++) begin
            clr_all(); set_wr(i % 2, 60 + i, 32'h0000_0600 + i); step();
        end
        clr_all(); step(); step();
        for (int p = 0; p < RP; p++) begin
            set_rd(0, p, 60 + p);
            set_rd(1, p, 64 + p);
        end
        step();
        for (int p = 0; p < RP; p++) begin
            exp_hit(0, p, 32'h600 + p, p % 2 == 1, "R9");
            exp_hit(1, p, 32'h604 + p, p % 2 == 1, "R9");
        end
        clr_all(); step();
    endtask

    task automatic t_override();
        clr_all(); set_wr(1, 70, 32'h6100_0070); step();
        clr_all(); set_wr(0, 70, 32'h6000_0070); step();
        clr_all(); set_rd(0, 0, 70); set_rd(1, 0, 70); step();
        exp_hit(0, 0, 32'h6000_0070, 1'b0, "R10");
        exp_stall(1, 0, "R10");
        clr_all(); step();
        exp_hit(1, 0, 32'h6000_0070, 1'b0, "R10");
        clr_all(); step();
    endtask

    initial begin
        clr_all();
        #(8*200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clr_all();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        t_reset();
        t_local();
        t_remote_stale();
        t_remote_late();
        t_same_cycle();
        t_collision();
        t_stall_ignore();
        t_ports();
        t_override();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule